// File: doc/BRIEF.md
# SMBus Target Front End

This block is the serial side of a bus target on the system management bus. It samples the clock and data lines with the system clock, cleans them up, and finds start and stop conditions. It shifts bytes in and out, compares the incoming 7-bit address with one of six fixed addresses, and drives the acknowledge bit. Writes are passed to a simple register port, and reads are served from it. The first byte of a write loads an internal register pointer. Every later byte of a write or a read uses that pointer and then advances it.

The block also answers the Alert Response Address while it has an alert pending, replying with its own address. It drops back to idle when it sees a stop condition. It also drops back to idle when both lines stay high for too long, or, once software allows it, when the clock line stays low for too long. The only piece of register state kept inside is the timeout-disable bit of the configuration register.

The state machine has eight states:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a start condition |
| ST_ADDR | Shifting in the address byte |
| ST_ADDR_ACK | Driving the acknowledge bit for a matching address |
| ST_WR_BYTE | Shifting in a written byte |
| ST_WR_ACK | Driving the acknowledge bit for a written byte |
| ST_RD_BYTE | Shifting out a read byte |
| ST_RD_ACK | Host acknowledge slot after a read byte |
| ST_IGNORE | Target off the bus until the next start or stop |

Named transitions:
- start (from any state to ST_ADDR);
- stop, idle timeout and clock-low timeout (from any state to ST_IDLE);
- addr_hit (ST_ADDR to ST_ADDR_ACK);
- addr_miss (ST_ADDR to ST_IGNORE);
- go_write and go_read (ST_ADDR_ACK to ST_WR_BYTE or ST_RD_BYTE);
- byte_in (ST_WR_BYTE to ST_WR_ACK);
- next_in (ST_WR_ACK to ST_WR_BYTE);
- byte_out (ST_RD_BYTE to ST_RD_ACK);
- host_more (ST_RD_ACK to ST_RD_BYTE);
- host_done (ST_RD_ACK to ST_IGNORE, when the host not-acknowledges or after an alert reply).

Top module: `smb_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `alert_pend` is 0 and `reg_we` is 0. The configuration register's timeout-disable bit resets to 1, so the clock-low timeout starts out off.
- R2: `addr_sel` chooses the device address as follows: 0 gives 0101110, 1 gives 0101111, 2 gives 0101100, 3 gives 0101101, 4 gives 1001100 and 5 gives 1001101. The values 6 and 7 both give 0101110.
- R3: The target pulls SDA low (`sda_oe`=1) during the ninth clock of a byte in two cases: an address byte whose upper 7 bits match, and every byte written to it. After a non-matching address it acknowledges nothing until the next start.
- R4: In a write, the first byte after the address (R/W bit 0) loads the register pointer. Each later byte gives one `reg_we` pulse of one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and the pointer then advances by one.
- R5: In a read (R/W bit 1), each byte is `reg_rdata` taken at the current pointer. It is sent most significant bit first, and the pointer advances by one after every byte.
- R6: When the host leaves SDA high in the acknowledge slot after a read byte, the target releases SDA. It then drives nothing until the next start or stop.
- R7: A start condition without a stop in between begins a new address phase and keeps the register pointer.
- R8: A stop condition (SDA rising while SCL is high) returns the target to idle. Bytes clocked afterwards without a new start are not acknowledged.
- R9: A rising edge on `alert_i` sets `alert_pend`.
  - While `alert_pend` is 1, a read to address 0001100 is acknowledged and returns the device address in bits 7..1 with bit 0 equal to 0.
  - `alert_pend` clears in that byte's acknowledge slot.
  - While `alert_pend` is 0, that address is not acknowledged.
- R10: When filtered SCL and SDA are both high for IDLE_CYCLES system clocks, the protocol state returns to idle. This holds even in the middle of a byte.
- R11: When the clock-low timeout is enabled and filtered SCL is low for LOW_CYCLES system clocks, the target returns to idle and releases SDA. When it is disabled, SCL may stay low without limit.
- R12: The timeout-disable bit is bit 6 of register 0x20. A write to 0x20 updates it, with 0 enabling the clock-low timeout, and the write is also passed out on the register port.
- R13: SCL or SDA pulses shorter than three system clocks do not reach the protocol logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 3 | Device address select |
| alert_i | input | 1 | Alert request; a rising edge makes an alert pending |
| alert_pend | output | 1 | Alert pending, cleared by an alert response read |
| reg_addr | output | 8 | Register pointer, used for reads and writes |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational from the register file |

## Verification
The hardest situation to reach from the ports is a timeout that lands in the middle of an active transfer.

For the clock-low case, the bench stops clocking partway through the address acknowledge, while the target is pulling SDA low. It holds SCL low well past LOW_CYCLES and reads the data line before raising SCL again. It does this with the disable bit at its reset value and after several writes to register 0x20, so both the enable path and the bit position show at the ports.

For the idle case, the bench stretches the high phase of a single `1` address bit beyond IDLE_CYCLES. An address that would otherwise match then goes unacknowledged.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } smb_state_e;

    // Alert response address (7-bit)
    localparam logic [6:0] ARA_ADDR = 7'h0C;
    // Configuration register holding the timeout-disable bit
    localparam logic [7:0] CFG_REG  = 8'h20;
    localparam int         DIS_BIT  = 6;

    // Device address picked by the 3-bit select input
    function automatic logic [6:0] sel_to_addr(input logic [2:0] sel);
        logic [6:0] a;
        unique case (sel)
            3'd0:    a = 7'b0101110;
            3'd1:    a = 7'b0101111;
            3'd2:    a = 7'b0101100;
            3'd3:    a = 7'b0101101;
            3'd4:    a = 7'b1001100;
            3'd5:    a = 7'b1001101;
            default: a = 7'b0101110;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/smb_filter.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a majority-free agreement filter:
// the output only moves once LEN consecutive samples agree.
module smb_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HW = (LEN < 2) ? 2 : LEN;

    logic [1:0]    sync_q;
    logic [HW-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[HW-2:0], sync_q[1]};
            if (&hist_q) begin
                dout <= 1'b1;
            end else if (~|hist_q) begin
                dout <= 1'b0;
            end
        end
    end

    // R13: the filtered line only rises after a full run of high samples
    a_r13_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(sync_q[1]));

endmodule

// File: rtl/smb_holdcnt.sv
`timescale 1ns/1ps
// Counts consecutive cycles of a condition; pulses once when LIMIT is reached.
module smb_holdcnt #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int          CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= cond && (cnt_q == LAST);
            if (!cond) begin
                cnt_q <= '0;
            end else if (cnt_q != TOP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R10/R11 share this counter: a hit only follows a cycle with the condition true
    a_r11_hit_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(cond));

    a_r10_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/smb_target.sv
`timescale 1ns/1ps
module smb_target
    import smb_pkg::*;
#(
    parameter int LOW_CYCLES  = 7_500_000,
    parameter int IDLE_CYCLES = 37_500,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] addr_sel,
    input  logic       alert_i,
    output logic       alert_pend,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_filter #(.LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic start_det, stop_det, scl_rise, scl_fall;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;

    // ---------------- timeouts ----------------
    logic dis_to_q;
    logic low_hit, idle_hit;

    smb_holdcnt #(.LIMIT(LOW_CYCLES)) u_low_to (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (~scl_f & ~dis_to_q),
        .hit  (low_hit)
    );

    smb_holdcnt #(.LIMIT(IDLE_CYCLES)) u_idle_to (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (scl_f & sda_f),
        .hit  (idle_hit)
    );

    logic abort;
    assign abort = stop_det | low_hit | idle_hit;

    // ---------------- protocol state ----------------
    smb_state_e state, state_n;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q;
    logic [7:0] ptr_q;
    logic       ptr_set_q;
    logic       adv_q;
    logic       ara_mode_q;
    logic       host_ack_q;
    logic       alert_q;
    logic       we_q;
    logic [7:0] wdata_q;

    logic [6:0] own_addr;
    logic       addr_hit;
    assign own_addr = sel_to_addr(addr_sel);
    assign addr_hit = (shreg_q[7:1] == own_addr) ||
                      ((shreg_q[7:1] == ARA_ADDR) && shreg_q[0] && alert_pend);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (abort) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && bitcnt_q == 4'd8) begin
                        state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        state_n = shreg_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_fall && bitcnt_q == 4'd8) begin
                        state_n = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_n = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall && bitcnt_q == 4'd7) begin
                        state_n = ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        state_n = (host_ack_q && !ara_mode_q) ? ST_RD_BYTE : ST_IGNORE;
                    end
                end
                ST_IGNORE:   state_n = ST_IGNORE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            ptr_q      <= '0;
            ptr_set_q  <= 1'b0;
            adv_q      <= 1'b0;
            ara_mode_q <= 1'b0;
            host_ack_q <= 1'b0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            dis_to_q   <= 1'b1;
        end else begin
            we_q <= 1'b0;
            if (abort) begin
                bitcnt_q   <= '0;
                ara_mode_q <= 1'b0;
            end else if (start_det) begin
                bitcnt_q   <= '0;
                ptr_set_q  <= 1'b0;
                ara_mode_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            ara_mode_q <= (shreg_q[7:1] == ARA_ADDR);
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (shreg_q[0]) begin
                                shreg_q <= ara_mode_q ? {own_addr, 1'b0} : reg_rdata;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            adv_q <= ptr_set_q;
                            if (!ptr_set_q) begin
                                ptr_q     <= shreg_q;
                                ptr_set_q <= 1'b1;
                            end else begin
                                we_q    <= 1'b1;
                                wdata_q <= shreg_q;
                                if (ptr_q == CFG_REG) begin
                                    dis_to_q <= shreg_q[DIS_BIT];
                                end
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (adv_q) begin
                                ptr_q <= ptr_q + 1'b1;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall && bitcnt_q != 4'd7) begin
                            shreg_q  <= {shreg_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            host_ack_q <= ~sda_f;
                            if (!ara_mode_q) begin
                                ptr_q <= ptr_q + 1'b1;
                            end
                        end else if (scl_fall) begin
                            bitcnt_q <= '0;
                            shreg_q  <= reg_rdata;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // alert pending flag: set on a rising request, cleared in the reply's ack slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q    <= 1'b0;
            alert_pend <= 1'b0;
        end else begin
            alert_q <= alert_i;
            if (alert_i && !alert_q) begin
                alert_pend <= 1'b1;
            end else if (state == ST_RD_ACK && ara_mode_q && scl_rise && !abort && !start_det) begin
                alert_pend <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~shreg_q[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    // ---------------- assertions ----------------
    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r6_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !host_ack_q) |=> !sda_oe);

    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    a_r9_alert_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_pend) |-> $past(state == ST_RD_ACK && ara_mode_q));

    a_r10_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |=> (state == ST_IDLE));

    a_r11_low_release: assert property (@(posedge clk) disable iff (!rst_n)
        low_hit |=> !sda_oe);

    a_r12_cfg_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dis_to_q) |-> $past(state == ST_WR_BYTE && ptr_q == CFG_REG && ptr_set_q));

endmodule

// File: tb/tb_smb_target.sv
`timescale 1ns/1ps
module tb_smb_target;

    localparam int LOW  = 3000;
    localparam int IDLE = 1000;
    localparam int Q    = 20;
    localparam int HOLD = 1200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       alert_i = 1'b0;
    logic       sda_oe, alert_pend, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_line;

    int checks = 0;
    int errors = 0;

    logic [7:0] regmem [256];

    always #2 clk = ~clk;

    assign sda_line  = ~(host_low | sda_oe);
    assign reg_rdata = regmem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) regmem[reg_addr] <= reg_wdata;
    end

    smb_target #(.LOW_CYCLES(LOW), .IDLE_CYCLES(IDLE), .FILT_LEN(3)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(sel), .alert_i(alert_i), .alert_pend(alert_pend),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    function automatic logic [6:0] exp_addr(input int s);
        case (s)
            1: return 7'b0101111;
            2: return 7'b0101100;
            3: return 7'b0101101;
            4: return 7'b1001100;
            5: return 7'b1001101;
            default: return 7'b0101110;
        endcase
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // ---------------- bus primitives ----------------
    task automatic bus_start();
        cyc(Q); host_low = 1'b0;
        cyc(Q); scl = 1'b1;
        cyc(Q); host_low = 1'b1;
        cyc(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(Q); host_low = 1'b1;
        cyc(Q); scl = 1'b1;
        cyc(Q); host_low = 1'b0;
        cyc(Q);
    endtask

    task automatic put_bit(input bit v, input bit glitch, input int hold);
        cyc(Q); host_low = ~v;
        if (glitch) begin
            cyc(5); scl = 1'b1; cyc(2); scl = 1'b0; cyc(Q - 7);
        end else begin
            cyc(Q);
        end
        scl = 1'b1;
        cyc(2 * Q + hold);
        scl = 1'b0;
    endtask

    task automatic get_bit(output bit v);
        cyc(Q); host_low = 1'b0;
        cyc(Q); scl = 1'b1;
        cyc(Q); v = sda_line;
        cyc(Q); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_bit, input int hold_bit,
                             output bit ack);
        bit v;
        for (int i = 7; i >= 0; i--) begin
            put_bit(b[i], i == glitch_bit, (i == hold_bit) ? HOLD : 0);
        end
        get_bit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        bit v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(~ack, 1'b0, 0);
    endtask

    task automatic write_reg(input logic [7:0] ra, input logic [7:0] d, input string req);
        bit a;
        bus_start();
        send_byte(8'h5C, -1, -1, a); chk(a, req, a, 1);
        send_byte(ra, -1, -1, a);    chk(a, req, a, 1);
        send_byte(d, -1, -1, a);     chk(a, req, a, 1);
        bus_stop();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(alert_pend == 1'b0, "R1 alert_pend", alert_pend, 0);
        chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
    endtask

    task automatic t_addr_table();
        bit a;
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            bus_start();
            send_byte({exp_addr(s), 1'b0}, -1, -1, a);
            chk(a, "R2 address select", a, 1);
            bus_stop();
        end
        sel = 3'd0;
        bus_start();
        send_byte(8'h5E, -1, -1, a);
        chk(!a, "R3 wrong address nacked", a, 0);
        send_byte(8'h00, -1, -1, a);
        chk(!a, "R3 bytes after miss ignored", a, 0);
        bus_stop();
    endtask

    task automatic t_write();
        bit a;
        sel = 3'd0;
        bus_start();
        send_byte(8'h5C, -1, -1, a); chk(a, "R3 address ack", a, 1);
        send_byte(8'h10, -1, -1, a); chk(a, "R3 pointer ack", a, 1);
        send_byte(8'hA5, -1, -1, a); chk(a, "R3 data ack", a, 1);
        send_byte(8'h3C, -1, -1, a); chk(a, "R3 data ack", a, 1);
        bus_stop();
        chk(regmem[8'h10] == 8'hA5, "R4 first write", regmem[8'h10], 8'hA5);
        chk(regmem[8'h11] == 8'h3C, "R4 second write", regmem[8'h11], 8'h3C);
        chk(regmem[8'h0F] == (8'h0F ^ 8'h5A), "R4 pointer byte not written",
            regmem[8'h0F], 8'h0F ^ 8'h5A);
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h5C, -1, -1, a);
        send_byte(8'h10, -1, -1, a);
        bus_start();
        send_byte(8'h5D, -1, -1, a); chk(a, "R5 read address ack", a, 1);
        recv_byte(1'b1, b); chk(b == 8'hA5, "R5 first read byte", b, 8'hA5);
        recv_byte(1'b0, b); chk(b == 8'h3C, "R5 second read byte", b, 8'h3C);
        bus_stop();
        bus_start();
        send_byte(8'h5D, -1, -1, a);
        recv_byte(1'b0, b);
        chk(b == (8'h12 ^ 8'h5A), "R5 pointer advanced across transfers", b, 8'h12 ^ 8'h5A);
        // R6: after the NACK the target must stay off the bus
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R6 no drive after nack", b, 8'hFF);
        chk(sda_oe == 1'b0, "R6 sda released", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_rstart();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h5C, -1, -1, a);
        send_byte(8'h30, -1, -1, a);
        bus_start();
        send_byte(8'h5D, -1, -1, a); chk(a, "R7 ack after repeated start", a, 1);
        recv_byte(1'b0, b); chk(b == (8'h30 ^ 8'h5A), "R7 read at pointer", b, 8'h30 ^ 8'h5A);
        bus_start();
        send_byte(8'h5D, -1, -1, a); chk(a, "R7 second repeated start ack", a, 1);
        recv_byte(1'b0, b); chk(b == (8'h31 ^ 8'h5A), "R7 pointer kept", b, 8'h31 ^ 8'h5A);
        bus_stop();
    endtask

    task automatic t_stop();
        bit a;
        bus_start();
        send_byte(8'h5C, -1, -1, a); chk(a, "R8 ack before stop", a, 1);
        bus_stop();
        cyc(Q); scl = 1'b0;
        send_byte(8'h5C, -1, -1, a);
        chk(!a, "R8 no ack without new start", a, 0);
        bus_stop();
    endtask

    task automatic t_ara();
        bit a;
        logic [7:0] b;
        sel = 3'd2;
        bus_start();
        send_byte(8'h19, -1, -1, a);
        chk(!a, "R9 alert address ignored when idle", a, 0);
        bus_stop();
        alert_i = 1'b1; cyc(4); alert_i = 1'b0; cyc(2);
        chk(alert_pend == 1'b1, "R9 alert pending set", alert_pend, 1);
        bus_start();
        send_byte(8'h19, -1, -1, a); chk(a, "R9 alert address ack", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'h58, "R9 reply carries own address", b, 8'h58);
        bus_stop();
        chk(alert_pend == 1'b0, "R9 alert pending cleared", alert_pend, 0);
        bus_start();
        send_byte(8'h19, -1, -1, a);
        chk(!a, "R9 no ack once cleared", a, 0);
        bus_stop();
        sel = 3'd0;
    endtask

    task automatic t_filter();
        bit a;
        bus_start();
        send_byte(8'h5C, 3, -1, a);
        chk(a, "R13 short SCL pulse ignored", a, 1);
        bus_stop();
    endtask

    task automatic t_idle();
        bit a;
        bus_start();
        send_byte(8'h5C, -1, 4, a);
        chk(!a, "R10 idle timeout mid-byte", a, 0);
        bus_stop();
    endtask

    // holds SCL low in the address ack slot; returns the data line seen late in the hold
    task automatic low_probe(output bit line);
        bit v;
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'(8'h5C >> i), 1'b0, 0);
        end
        cyc(Q); host_low = 1'b0;
        cyc(LOW + 500);
        line = sda_line;
        cyc(500);
        scl = 1'b1;
        cyc(2 * Q);
        v = sda_line;
        scl = 1'b0;
        bus_stop();
    endtask

    task automatic t_low();
        bit line;
        low_probe(line);
        chk(line == 1'b0, "R11 timeout off after reset (R1)", line, 0);
        write_reg(8'h20, 8'h00, "R12 config write ack");
        chk(regmem[8'h20] == 8'h00, "R12 config passed to port", regmem[8'h20], 0);
        low_probe(line);
        chk(line == 1'b1, "R11 clock-low timeout releases", line, 1);
        write_reg(8'h20, 8'h40, "R12 config write ack");
        low_probe(line);
        chk(line == 1'b0, "R12 bit 6 disables timeout", line, 0);
        write_reg(8'h20, 8'hBF, "R12 config write ack");
        low_probe(line);
        chk(line == 1'b1, "R12 other bits leave timeout enabled", line, 1);
    endtask

    // ---------------- main ----------------
    initial begin
        for (int i = 0; i < 256; i++) regmem[i] = 8'(i) ^ 8'h5A;
        cyc(5);
        rst_n = 1'b1;
        cyc(10);
        t_reset();
        t_addr_table();
        t_write();
        t_read();
        t_rstart();
        t_stop();
        t_ara();
        t_filter();
        t_idle();
        t_low();
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

endmodule